// File: doc/BRIEF.md
# SIMD Warp Compaction Unit

This unit gathers the partially active warps of one thread block at a divergence or reconvergence barrier and repacks their threads into as few warps as possible. A thread always stays in its home SIMD lane. Each lane has its own priority encoder. On every cycle, that encoder takes the lowest-numbered input warp that still has a thread waiting in that lane. The threads picked across the lanes together form one output warp.

A single `load` pulse presents all input lane masks and thread identifiers together. From the next cycle on, the unit issues one compacted warp per cycle. When no waiting threads remain, it raises a one-cycle `done` and shows how many warps it produced. Later logic can compare that count with the number of input warps to judge whether compaction paid off. The lane count, the warps per thread block and the identifier width are parameters.

Top module: `warp_compactor`

## Requirements
- R1: After reset, `out_valid`, `done` and `warp_count` are all zero.
- R2: When `load` is high and the unit is idle, the masks and identifiers are captured on that clock edge, and the first compacted warp appears on the outputs in the following cycle.
- R3: In every output lane `l`, `out_tid` carries the identifier that was loaded for lane `l` of some input warp; threads never change lane.
- R4: In each lane, the thread issued is the one from the lowest-numbered input warp whose bit is still pending for that lane. Input bit `w*LANES+l` belongs to warp `w`, lane `l`.
- R5: A lane with no pending thread has its `out_mask` bit at 0 and its `out_tid` field at zero.
- R6: Warps are issued on consecutive cycles, with `out_mask` non-zero whenever `out_valid` is high. The number of valid cycles equals the largest per-lane count of set bits over the input masks.
- R7: Every loaded active thread is issued exactly once, and `out_valid` is low once all have been issued.
- R8: `done` is high for exactly one cycle, namely the cycle after the last valid warp, and `out_valid` is low in that cycle.
- R9: `warp_count` equals the number of warps issued. It is valid when `done` is high and keeps its value until the next accepted load.
- R10: A load with all masks zero issues no warp, raises `done` in the next cycle and reports a count of zero.
- R11: A `load` pulse that arrives while warps are still being issued is ignored: the current sequence is unaffected, and no further warp follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| load | input | 1 | Capture a new thread-block set when idle |
| in_mask | input | WARPS*LANES | Active bits, warp `w` lane `l` at bit `w*LANES+l` |
| in_tid | input | WARPS*LANES*TID_W | Thread identifiers, slot `w*LANES+l` at bits `(w*LANES+l)*TID_W` upward |
| out_valid | output | 1 | A compacted warp is present on the outputs |
| out_mask | output | LANES | Active lanes of the compacted warp |
| out_tid | output | LANES*TID_W | Identifier per lane, lane `l` at bits `l*TID_W` upward |
| done | output | 1 | One-cycle pulse after the last warp has been issued |
| warp_count | output | $clog2(WARPS+1) | Number of compacted warps produced |

## Verification
The embedded properties assume that `load` is honoured only while the unit is idle. They also assume that the pending set can only shrink between loads, by exactly the lanes just issued. The bench keeps to the 4-lane, 2-warp configuration and sweeps all 256 mask combinations. It gives every combination its own distinct identifiers so that a lane swap or a wrong warp pick shows up in the data. On a fixed subset of combinations it raises `load` with the complemented masks while a sequence is running, which exercises the rule that such a pulse is ignored. All other stimulus changes only while the unit is idle.

// File: rtl/wcu_pkg.sv
// Shared helpers for the warp compaction unit.
// Assumes the flat layout used everywhere: slot index = warp * lanes + lane.
package wcu_pkg;
    // Flat slot index of a given warp and lane
    function automatic int slot_of(input int w, input int l, input int lanes);
        return w * lanes + l;
    endfunction
endpackage

// File: rtl/wcu_lane_pick.sv
// Per-lane priority encoder: selects the lowest-numbered warp still pending
// in this lane and forwards that warp's identifier for the lane.
// Assumes pend_col bit w is the pending flag of warp w for this lane.
module wcu_lane_pick #(
    parameter int WARPS = 2,
    parameter int TID_W = 8
) (
    input  logic [WARPS-1:0]       pend_col,
    input  logic [WARPS*TID_W-1:0] tid_col,
    output logic                   hit,
    output logic [WARPS-1:0]       grant,
    output logic [TID_W-1:0]       tid
);
    // Lowest-index-first search; identifier is zero when nothing is pending
    always_comb begin
        hit   = 1'b0;
        grant = '0;
        tid   = '0;
        for (int w = 0; w < WARPS; w++) begin
            if (pend_col[w] && !hit) begin
                hit      = 1'b1;
                grant[w] = 1'b1;
                tid      = tid_col[w*TID_W +: TID_W];
            end
        end
    end
endmodule

// File: rtl/wcu_tally.sv
// Counter of compacted warps issued since the last accepted load.
// Assumes step is asserted at most MAXV times between two clears.
module wcu_tally #(
    parameter int MAXV  = 2,
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             step,
    output logic [CNT_W-1:0] count
);
    // Clear on an accepted load, advance once per issued warp
    always_ff @(posedge clk) begin
        if (!rst_n)     count <= '0;
        else if (clear) count <= '0;
        else if (step)  count <= count + 1'b1;
    end

    // R9: the count never goes past the number of input warps
    a_r9_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CNT_W'(MAXV));
endmodule

// File: rtl/warp_compactor.sv
// Warp compaction unit top. It holds the pending thread set of one thread
// block and, through one priority encoder per lane, issues one lane-preserving
// compacted warp per cycle until the set is empty, then pulses done.
// Assumes load is only acted upon while idle; a load while busy is dropped.
module warp_compactor
    import wcu_pkg::*;
#(
    parameter int LANES = 4,
    parameter int WARPS = 2,
    parameter int TID_W = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    input  logic [WARPS*LANES-1:0]       in_mask,
    input  logic [WARPS*LANES*TID_W-1:0] in_tid,
    output logic                         out_valid,
    output logic [LANES-1:0]             out_mask,
    output logic [LANES*TID_W-1:0]       out_tid,
    output logic                         done,
    output logic [$clog2(WARPS+1)-1:0]   warp_count
);
    localparam int SLOTS = WARPS * LANES;
    localparam int CNT_W = $clog2(WARPS + 1);

    logic [SLOTS-1:0]       pend_q;
    logic [SLOTS*TID_W-1:0] tid_q;
    logic                   busy_q;
    logic                   done_q;
    logic [SLOTS-1:0]       clr;
    logic [SLOTS-1:0]       pend_next;
    logic                   accept;

    logic [WARPS-1:0]       col_pend  [LANES];
    logic [WARPS-1:0]       col_grant [LANES];
    logic [WARPS*TID_W-1:0] col_tid   [LANES];

    // Regroup the flat storage into per-lane columns and gather the clear mask
    for (genvar l = 0; l < LANES; l++) begin : g_lane
        for (genvar w = 0; w < WARPS; w++) begin : g_warp
            localparam int S = slot_of(w, l, LANES);
            assign col_pend[l][w]                 = pend_q[S];
            assign col_tid[l][w*TID_W +: TID_W]   = tid_q[S*TID_W +: TID_W];
            assign clr[S]                         = col_grant[l][w];
        end
        wcu_lane_pick #(.WARPS(WARPS), .TID_W(TID_W)) u_pick (
            .pend_col (col_pend[l]),
            .tid_col  (col_tid[l]),
            .hit      (out_mask[l]),
            .grant    (col_grant[l]),
            .tid      (out_tid[l*TID_W +: TID_W])
        );
    end

    assign accept    = load && !busy_q;
    assign pend_next = pend_q & ~clr;
    assign out_valid = busy_q;
    assign done      = done_q;

    // Load a new set when idle, otherwise retire the lanes issued this cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend_q <= '0;
            tid_q  <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
        end else if (accept) begin
            pend_q <= in_mask;
            tid_q  <= in_tid;
            busy_q <= |in_mask;
            done_q <= ~|in_mask;
        end else if (busy_q) begin
            pend_q <= pend_next;
            busy_q <= |pend_next;
            done_q <= ~|pend_next;
        end else begin
            done_q <= 1'b0;
        end
    end

    wcu_tally #(.MAXV(WARPS), .CNT_W(CNT_W)) u_tally (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (accept),
        .step  (busy_q),
        .count (warp_count)
    );

    // R6: a valid warp always carries at least one thread
    a_r6_valid_nonempty: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (out_mask != '0));

    // R7: each busy cycle removes exactly the issued threads from the pending set
    a_r7_drain_exact: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> ($countones(pend_q) + $countones($past(out_mask))
                    == $countones($past(pend_q))));

    // R8: done is never raised while warps are still being issued
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !out_valid);

    // R8: the end of a sequence is always announced by done
    a_r8_end_flags_done: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q) |-> done);

    // R11: while busy the pending set only shrinks, so a new load cannot add work
    a_r11_no_reload: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q |=> ((pend_q & ~$past(pend_q)) == '0));

    // R9: the count holds while idle with no load
    a_r9_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_q && !load) |=> $stable(warp_count));
endmodule

// File: tb/warp_compactor_test.sv
// Exhaustive sweep over every mask combination of a 4-lane, 2-warp block.
module warp_compactor_test;
    localparam int LANES      = 4;
    localparam int WARPS      = 2;
    localparam int TID_W      = 8;
    localparam int SLOTS      = WARPS * LANES;
    localparam int CNT_W      = $clog2(WARPS + 1);
    localparam int CLK_PERIOD = 10;

    logic                   clk;
    logic                   rst_n;
    logic                   load;
    logic [SLOTS-1:0]       in_mask;
    logic [SLOTS*TID_W-1:0] in_tid;
    logic                   out_valid;
    logic [LANES-1:0]       out_mask;
    logic [LANES*TID_W-1:0] out_tid;
    logic                   done;
    logic [CNT_W-1:0]       warp_count;

    int checks = 0;
    int fails  = 0;

    warp_compactor #(.LANES(LANES), .WARPS(WARPS), .TID_W(TID_W)) uut (
        .clk(clk), .rst_n(rst_n), .load(load), .in_mask(in_mask), .in_tid(in_tid),
        .out_valid(out_valid), .out_mask(out_mask), .out_tid(out_tid),
        .done(done), .warp_count(warp_count)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic run_case(input int m, input bit poke);
        logic [SLOTS-1:0]       model;
        logic [SLOTS*TID_W-1:0] saved;
        int exp_cnt;
        int cyc;
        exp_cnt = 0;
        for (int l = 0; l < LANES; l++) begin
            int pc;
            pc = 0;
            for (int w = 0; w < WARPS; w++) pc += m[w*LANES+l];
            if (pc > exp_cnt) exp_cnt = pc;
        end
        @(negedge clk);
        in_mask = SLOTS'(m);
        for (int s = 0; s < SLOTS; s++)
            in_tid[s*TID_W +: TID_W] = TID_W'(m * 3 + s * 17 + 1);
        saved = in_tid;
        model = SLOTS'(m);
        load  = 1'b1;
        @(negedge clk);
        load = 1'b0;
        cyc  = 0;
        while (model != '0 && cyc <= WARPS) begin
            check(out_valid == 1'b1, "R2", "out_valid during issue", int'(out_valid), 1);
            for (int l = 0; l < LANES; l++) begin
                bit found;
                logic [TID_W-1:0] etid;
                found = 1'b0;
                etid  = '0;
                for (int w = 0; w < WARPS; w++) begin
                    if (!found && model[w*LANES+l]) begin
                        found = 1'b1;
                        etid  = saved[(w*LANES+l)*TID_W +: TID_W];
                        model[w*LANES+l] = 1'b0;
                    end
                end
                check(out_mask[l] == found, "R4", "lane mask bit",
                      int'(out_mask[l]), int'(found));
                if (found)
                    check(out_tid[l*TID_W +: TID_W] == etid, "R3", "lane thread id",
                          int'(out_tid[l*TID_W +: TID_W]), int'(etid));
                else
                    check(out_tid[l*TID_W +: TID_W] == '0, "R5", "idle lane id",
                          int'(out_tid[l*TID_W +: TID_W]), 0);
            end
            cyc++;
            if (poke && cyc == 1) begin
                load    = 1'b1;
                in_mask = ~SLOTS'(m);
                in_tid  = ~in_tid;
            end
            @(negedge clk);
            load = 1'b0;
        end
        check(cyc == exp_cnt, "R6", "valid cycle count", cyc, exp_cnt);
        check(out_valid == 1'b0, "R7", "valid after drain", int'(out_valid), 0);
        if (m == 0) begin
            check(done == 1'b1, "R10", "done on empty load", int'(done), 1);
            check(warp_count == '0, "R10", "count on empty load", int'(warp_count), 0);
        end else begin
            check(done == 1'b1, "R8", "done after last warp", int'(done), 1);
            check(int'(warp_count) == exp_cnt, "R9", "warp count",
                  int'(warp_count), exp_cnt);
        end
        @(negedge clk);
        check(done == 1'b0, "R8", "done single cycle", int'(done), 0);
        check(int'(warp_count) == exp_cnt, "R9", "count held", int'(warp_count), exp_cnt);
        if (poke)
            check(out_valid == 1'b0, "R11", "load while busy ignored", int'(out_valid), 0);
    endtask

    initial begin
        rst_n   = 1'b0;
        load    = 1'b0;
        in_mask = '0;
        in_tid  = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(out_valid == 1'b0, "R1", "reset out_valid", int'(out_valid), 0);
        check(done == 1'b0, "R1", "reset done", int'(done), 0);
        check(warp_count == '0, "R1", "reset count", int'(warp_count), 0);
        rst_n = 1'b1;
        for (int m = 0; m < (1 << SLOTS); m++)
            run_case(m, (m % 5) == 2);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule